// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one read or write burst inside a bank of a synchronous DRAM. A start-read or start-write strobe loads a start column together with a burst length code and an ordering choice. From the next cycle on, the block presents one column per clock, together with a flag that marks the burst as running and a flag that marks its final beat.

Two orderings are supported. In the linear ordering the low address bits count upward and wrap inside the aligned window of the burst length. In the interleaved ordering the low bits of the start column are XORed with the beat index. A whole-page mode walks every column of the row and wraps from the top column back to column zero, and it keeps running until it is stopped. A stop strobe ends a burst on any cycle. A new start strobe on any cycle replaces the running burst.

All strobes are sampled on the rising clock edge. The outputs are driven from registers, so a command sampled at edge t shows its first column in the cycle that follows edge t.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and whenever no burst runs, `busy`, `final_beat` and `burst_is_wr` read 0 and `col_addr` reads 0.
- R2: A start strobe sampled at an edge makes `busy` 1 in the next cycle, with `col_addr` equal to the sampled `start_col`.
- R3: Linear ordering (`ilv_order` = 0) with finite length N: on beat k, the low log2(N) bits equal (start low bits + k) mod N, and the upper bits equal those of the start column.
- R4: Interleaved ordering (`ilv_order` = 1): on beat k, `col_addr` equals the start column with its low log2(N) bits XORed with k.
- R5: `len_sel` codes: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a whole page. The unused codes 3'b100 to 3'b110 give 8 beats. A finite burst keeps `busy` high for exactly N cycles.
- R6: A whole-page burst with linear ordering advances one column per cycle modulo 2^COL_W, so it wraps from the top column to 0. It runs until it is stopped or replaced, and it never raises `final_beat`.
- R7: Code 3'b111 combined with interleaved ordering gives an 8-beat interleaved burst.
- R8: `final_beat` is 1 only on the last beat of a finite burst. Unless a new start is sampled on that edge, the block is idle in the next cycle.
- R9: A stop strobe (`stop_burst`) sampled without a start ends the burst, so the block is idle in the next cycle. A stop sampled while idle has no effect.
- R10: A start sampled during a running burst restarts from its own column, length and ordering. When a start and a stop are sampled together, the start wins.
- R11: `start_col`, `len_sel` and `ilv_order` are latched only on a start. Changing them during a burst does not alter the running sequence.
- R12: `burst_is_wr` shows 1 during a burst begun by `start_wr`. If `start_rd` and `start_wr` are sampled together, the burst counts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_rd | input | 1 | Begin a read burst |
| start_wr | input | 1 | Begin a write burst |
| stop_burst | input | 1 | End the running burst |
| start_col | input | COL_W | First column of the burst |
| len_sel | input | 3 | Burst length code |
| ilv_order | input | 1 | 1 selects the interleaved ordering, 0 the linear ordering |
| col_addr | output | COL_W | Column of the current beat |
| busy | output | 1 | A burst is running |
| final_beat | output | 1 | Current beat is the last of a finite burst |
| burst_is_wr | output | 1 | Running burst is a write |

## Verification
Directed bursts use start columns that sit off the aligned window, such as column 13 at length 8 and column 6 at length 4. These separate true modulo wrap inside the window from a plain carry into the upper bits, and they separate the XOR ordering from an add. A whole-page burst started at column 510 shows the wrap to 0 and the absence of `final_beat`. The reserved length codes, the illegal interleaved page code, and stop or start strobes placed on the first, middle and final beats each isolate one priority or fallback rule. A long seeded random run mixes all lengths, both orderings, restarts and stops, and compares every cycle against a reference model in the bench.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    LEN_ONE  = 3'b000,
    LEN_TWO  = 3'b001,
    LEN_FOUR = 3'b010,
    LEN_OCT  = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  localparam int MAX_FIN_LOG = 3;  // longest finite burst is 2**3 beats

endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       len_sel,
  input  logic             ilv_order,
  output logic [COL_W-1:0] win_mask,
  output logic             page_mode
);

  function automatic logic [COL_W-1:0] low_ones(input int unsigned nbits);
    logic [COL_W-1:0] m;
    m = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < nbits) m[i] = 1'b1;
    end
    return m;
  endfunction

  int unsigned len_log;

  always_comb begin
    page_mode = 1'b0;
    case (len_sel)
      LEN_ONE:  len_log = 0;
      LEN_TWO:  len_log = 1;
      LEN_FOUR: len_log = 2;
      LEN_OCT:  len_log = MAX_FIN_LOG;
      LEN_PAGE: begin
        len_log   = MAX_FIN_LOG;
        page_mode = !ilv_order;  // R7: interleaved page falls back to 8
      end
      default:  len_log = MAX_FIN_LOG;  // R5: reserved codes act as 8
    endcase
    win_mask = page_mode ? '1 : low_ones(len_log);
  end

  always_comb begin
    assert_page_only_linear_R7: assert (!(page_mode && ilv_order));
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_wr,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             page_in,
  input  logic             ilv_in,
  output logic             run,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             page,
  output logic             ilv,
  output logic             wr,
  output logic             at_end
);

  assign at_end = run && !page && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      beat <= '0;
      base <= '0;
      mask <= '0;
      page <= 1'b0;
      ilv  <= 1'b0;
      wr   <= 1'b0;
    end else if (go) begin
      run  <= 1'b1;
      beat <= '0;
      base <= start_col;
      mask <= mask_in;
      page <= page_in;
      ilv  <= ilv_in;
      wr   <= go_wr;
    end else if (stop || at_end) begin
      run  <= 1'b0;
      beat <= '0;
    end else if (run) begin
      beat <= beat + COL_W'(1);
    end
  end

  assert_beat_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((beat & ~mask) == '0));
  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !go) |=> !run);
  assert_end_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !go) |=> !run);
  assert_start_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (run && beat == '0 && base == $past(start_col)));
  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !go && !stop && !at_end) |=> (run && beat == $past(beat) + COL_W'(1)));
  assert_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !go) |=> ($stable(base) && $stable(mask) && $stable(ilv) && $stable(page)));

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 9
) (
  input  logic             run,
  input  logic             ilv,
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  output logic [COL_W-1:0] col
);

  function automatic logic [COL_W-1:0] linear_col(input logic [COL_W-1:0] b,
                                                  input logic [COL_W-1:0] k,
                                                  input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + k) & m);
  endfunction

  function automatic logic [COL_W-1:0] xor_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] k,
                                               input logic [COL_W-1:0] m);
    return b ^ (k & m);
  endfunction

  logic [COL_W-1:0] lin_c, xor_c;

  assign lin_c = linear_col(base, beat, mask);
  assign xor_c = xor_col(base, beat, mask);
  assign col   = !run ? '0 : (ilv ? xor_c : lin_c);

  always_comb begin
    assert_upper_fixed_R3: assert (!run || ((col & ~mask) == (base & ~mask)));
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic             stop_burst,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv_order,
  output logic [COL_W-1:0] col_addr,
  output logic             busy,
  output logic             final_beat,
  output logic             burst_is_wr
);

  logic             go_any;
  logic [COL_W-1:0] dec_mask, r_beat, r_base, r_mask;
  logic             dec_page, r_page, r_ilv, r_wr;

  assign go_any = start_rd | start_wr;

  colgen_len_dec #(.COL_W(COL_W)) u_dec (
    .len_sel   (len_sel),
    .ilv_order (ilv_order),
    .win_mask  (dec_mask),
    .page_mode (dec_page)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_any),
    .go_wr     (start_wr),
    .stop      (stop_burst),
    .start_col (start_col),
    .mask_in   (dec_mask),
    .page_in   (dec_page),
    .ilv_in    (ilv_order),
    .run       (busy),
    .beat      (r_beat),
    .base      (r_base),
    .mask      (r_mask),
    .page      (r_page),
    .ilv       (r_ilv),
    .wr        (r_wr),
    .at_end    (final_beat)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .run  (busy),
    .ilv  (r_ilv),
    .base (r_base),
    .beat (r_beat),
    .mask (r_mask),
    .col  (col_addr)
  );

  assign burst_is_wr = busy & r_wr;

  assert_page_no_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && r_page) |-> !final_beat);
  assert_first_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |=> (busy && col_addr == $past(start_col)));
  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd && start_wr) |=> burst_is_wr);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (col_addr == '0 && !final_beat && !burst_is_wr));

endmodule

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;

  localparam int CW = 9;
  localparam int PAGE = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_rd = 1'b0, start_wr = 1'b0, stop_burst = 1'b0;
  logic [CW-1:0] start_col = '0;
  logic [2:0]    len_sel = 3'b000;
  logic          ilv_order = 1'b0;
  logic [CW-1:0] col_addr;
  logic          busy, final_beat, burst_is_wr;

  always #4 clk = ~clk;  // 125 MHz

  sdram_burst_colgen #(.COL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
    .stop_burst(stop_burst), .start_col(start_col), .len_sel(len_sel),
    .ilv_order(ilv_order), .col_addr(col_addr), .busy(busy),
    .final_beat(final_beat), .burst_is_wr(burst_is_wr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  bit m_act, m_ilv, m_wr;
  int m_base, m_k, m_len;  // m_len 0 means whole page

  function automatic int len_of(input logic [2:0] code, input bit il);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd7: return il ? 8 : 0;
      default: return 8;
    endcase
  endfunction

  function automatic int want_col();
    int lo;
    if (!m_act) return 0;
    if (m_len == 0) return (m_base + m_k) % PAGE;
    if (m_ilv) return m_base ^ m_k;
    lo = m_base % m_len;
    return (m_base - lo) + ((lo + m_k) % m_len);
  endfunction

  function automatic bit want_last();
    return m_act && m_len != 0 && m_k == m_len - 1;
  endfunction

  task automatic check(input string tag);
    int ec; bit el, ea, ew;
    ec = want_col(); el = want_last(); ea = m_act; ew = m_act && m_wr;
    n_chk++;
    if (int'(col_addr) != ec || final_beat != el || busy != ea || burst_is_wr != ew) begin
      n_bad++;
      $display("FAIL %s: col=%0d busy=%0b last=%0b wr=%0b expected col=%0d busy=%0b last=%0b wr=%0b",
               tag, col_addr, busy, final_beat, burst_is_wr, ec, ea, el, ew);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input bit tm, input int col,
                      input logic [2:0] code, input bit il, input string tag);
    start_rd = rd; start_wr = wr; stop_burst = tm;
    start_col = CW'(col); len_sel = code; ilv_order = il;
    @(posedge clk);
    if (rd || wr) begin
      m_act = 1; m_k = 0; m_base = col; m_len = len_of(code, il); m_ilv = il; m_wr = wr;
    end else if (tm) begin
      m_act = 0; m_k = 0;
    end else if (m_act) begin
      if (m_len != 0 && m_k == m_len - 1) begin m_act = 0; m_k = 0; end
      else m_k = (m_k + 1) % PAGE;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 3'd0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    m_act = 0; m_k = 0; m_base = 0; m_len = 1; m_ilv = 0; m_wr = 0;
    r = $urandom(32'h0c01_5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset");
    idle(2, "R1 idle");

    // R3: linear length 8 from 13 -> 13,14,15,8..12
    step(1, 0, 0, 13, 3'd3, 0, "R2 start");
    idle(8, "R3 linear wrap");
    // R4: interleave length 4 from 6 -> 6,7,4,5
    step(0, 1, 0, 6, 3'd2, 1, "R4 ilv");
    idle(4, "R4 ilv");
    step(1, 0, 0, 21, 3'd3, 1, "R4 ilv8");
    idle(8, "R4 ilv8");
    // R5: lengths and reserved codes
    step(1, 0, 0, 100, 3'd0, 0, "R5 len1");
    idle(1, "R5 len1");
    step(1, 0, 0, 101, 3'd1, 0, "R5 len2");
    idle(2, "R5 len2");
    step(1, 0, 0, 250, 3'd5, 0, "R5 reserved");
    idle(8, "R5 reserved");
    step(1, 0, 0, 7, 3'd4, 1, "R5 reserved ilv");
    idle(8, "R5 reserved ilv");
    // R6: whole page from 510, wraps to 0
    step(1, 0, 0, 510, 3'd7, 0, "R6 page");
    idle(600, "R6 page run");
    step(0, 0, 1, 0, 3'd0, 0, "R9 stop page");
    idle(2, "R9 after stop");
    // R7: interleave + page code = 8 beats
    step(0, 1, 0, 45, 3'd7, 1, "R7 fallback");
    idle(9, "R7 fallback");
    // R9: stop while idle has no effect; stop mid burst
    step(0, 0, 1, 0, 3'd0, 0, "R9 idle stop");
    step(1, 0, 0, 33, 3'd3, 0, "R9 start");
    idle(2, "R9 mid");
    step(0, 0, 1, 0, 3'd0, 0, "R9 stop mid");
    idle(1, "R9 after");
    // R10: restart mid burst, start beats stop, restart on final beat
    step(1, 0, 0, 64, 3'd3, 0, "R10 first");
    idle(3, "R10 first");
    step(0, 1, 1, 300, 3'd2, 1, "R10 restart with stop");
    idle(3, "R10 second");
    step(1, 0, 0, 9, 3'd1, 0, "R10 restart on final");
    idle(3, "R10 third");
    // R11: settings change mid burst ignored
    step(1, 0, 0, 130, 3'd3, 0, "R11 start");
    for (int i = 0; i < 8; i++) begin
      start_rd = 0; start_wr = 0; stop_burst = 0;
      start_col = CW'(i * 37); len_sel = 3'(i); ilv_order = i[0];
      @(posedge clk);
      if (m_len != 0 && m_k == m_len - 1) begin m_act = 0; m_k = 0; end
      else if (m_act) m_k = m_k + 1;
      @(negedge clk);
      check("R11 latched");
    end
    // R12: both strobes -> write
    step(1, 1, 0, 77, 3'd2, 0, "R12 both");
    idle(4, "R12 both");
    step(1, 0, 0, 78, 3'd2, 0, "R12 read");
    idle(4, "R12 read");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned p;
      bit rd, wr, tm, il;
      logic [2:0] code;
      p = $urandom % 100;
      rd = (p < 6); wr = (p >= 6 && p < 12) || (p == 12);
      if (p == 12) rd = 1;
      tm = ($urandom % 100) < 4;
      il = $urandom % 2;
      code = 3'($urandom % 8);
      step(rd, wr, tm, int'($urandom % PAGE), code, il, "R3 R4 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule